// File: doc/BRIEF.md
# SD Host Module Clock Generator

This block produces the card-side module clock of an SD/MMC host. All logic runs on one fast reference clock, `clk_i`, which stands for the peripheral PLL. The slow fixed oscillator reaches the block as a single-cycle strobe, `osc_tick_i`, already synchronised into `clk_i`. A 15-bit configuration word sets the following:

- which input provides the source ticks;
- a power-of-two pre-divider and a linear divider;
- an enable;
- an output-phase delay and a sample-phase delay;
- a timing-mode bit that bypasses both delays.

The divided clock leaves the block as a registered level on `mclk_o`. A one-cycle strobe on `smp_stb_o` marks the sample point for the host's capture logic.

Software writes the configuration word through a write-enable port into a shadow register. While the generator is running, the shadow is copied into the active configuration only on the source tick that ends a division period. Because of this, a change of divider, source, delays or enable never cuts a period short. While the generator is stopped, the shadow is copied on every cycle.

Top module: `mclk_gen`

## Requirements
- R1: After reset, and whenever the active enable bit (bit 14) is 0, `mclk_o` and `smp_stb_o` are 0. The word held in the shadow after reset is all zeros.
- R2: The total ratio is D = (M field + 1) << N field, with M in bits 3:0 and N in bits 5:4. `mclk_o` repeats every D source ticks and is high for ceil(D/2) of them, so a ratio of 1 gives a constant high level.
- R3: When source-select bit 6 is 1, every `clk_i` cycle is a source tick. When it is 0, only cycles with `osc_tick_i` high are source ticks, and the phase counter holds between them.
- R4: The output-delay field (bits 10:8, value k) delays the high window of `mclk_o` by k source ticks, wrapped within the period. k is clamped to D-1.
- R5: `smp_stb_o` pulses for one cycle on the source tick at phase s, where s is the sample-delay field (bits 13:11) clamped to D-1. It pulses only while the generator is enabled.
- R6: When mode bit 7 is 1, both delay fields are treated as 0.
- R7: While running, a written word becomes active only on the source tick at phase D-1, and the next period starts from phase 0. While stopped, a written word becomes active on the edge after the write edge.
- R8: Both outputs are registered. Each reflects the phase counter value that was present one `clk_i` cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock; also the PLL source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | Oscillator source tick, one cycle wide, synchronous to `clk_i` |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 15 | Configuration word |
| mclk_o | output | 1 | Divided module clock level |
| smp_stb_o | output | 1 | Sample-point strobe |

## Verification
The assertions assume that `osc_tick_i` is already synchronous to `clk_i` and lasts one cycle. They also assume that configuration writes are single-cycle strobes that may arrive at any phase. The checks on the phase counter and on holding the configuration rely on reset having been asserted before the first edge.

The stimulus drives the oscillator tick as a regular one-in-n pattern and changes the rate between segments. Writes land at arbitrary points in the period, including in the middle of a running one. Every value written uses only the defined fields, so the clamping and the mode-bypass paths are reached through legal words.

// File: rtl/mclkgen_pkg.sv
package mclkgen_pkg;
  parameter int M_W   = 4;
  parameter int N_W   = 2;
  parameter int DLY_W = 3;

  localparam int MAX_N = (1 << N_W) - 1;
  localparam int DIV_W = M_W + 1 + MAX_N;
  localparam int REG_W = M_W + N_W + 2 + 2 * DLY_W + 1;

  // msb first: en, sample delay, output delay, mode, source, n, m
  typedef struct packed {
    logic             en;
    logic [DLY_W-1:0] sdly;
    logic [DLY_W-1:0] odly;
    logic             mode;
    logic             src;
    logic [N_W-1:0]   n;
    logic [M_W-1:0]   m;
  } cfg_t;

  function automatic logic [DIV_W-1:0] ratio_of(cfg_t c);
    logic [DIV_W-1:0] base;
    base = DIV_W'({1'b0, c.m}) + DIV_W'(1);
    return base << c.n;
  endfunction

  function automatic logic [DIV_W-1:0] clamp_dly(logic [DLY_W-1:0] k,
                                                 logic [DIV_W-1:0] d);
    if (DIV_W'(k) >= d) return d - DIV_W'(1);
    return DIV_W'(k);
  endfunction
endpackage

// File: rtl/mclk_cfg_shadow.sv
module mclk_cfg_shadow
  import mclkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             shadow_o
);
  cfg_t shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '0;
    else if (we_i) shadow_q <= cfg_t'(wdata_i);
  end

  assign shadow_o = shadow_q;
endmodule

// File: rtl/mclk_div_core.sv
module mclk_div_core
  import mclkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             shadow_i,
  input  logic             osc_tick_i,
  output cfg_t             act_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] ratio_o,
  output logic             tick_o,
  output logic             term_o
);
  cfg_t             act_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio;
  logic             tick;
  logic             term;
  logic             load;

  assign ratio = ratio_of(act_q);
  assign tick  = act_q.src ? 1'b1 : osc_tick_i;
  assign term  = tick && (cnt_q == ratio - DIV_W'(1));
  // stopped: follow the shadow freely; running: only at period end
  assign load  = !act_q.en || term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      act_q <= shadow_i;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign act_o   = act_q;
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio;
  assign tick_o  = tick;
  assign term_o  = term;
endmodule

// File: rtl/mclk_phase_out.sv
module mclk_phase_out
  import mclkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             act_i,
  input  logic [DIV_W-1:0] cnt_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             tick_i,
  output logic             mclk_o,
  output logic             stb_o
);
  localparam int PH_W = DIV_W + 1;

  logic [DIV_W-1:0] odly, sdly;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  hi_len;
  logic             mclk_d, stb_d;
  logic             mclk_q, stb_q;

  assign odly = act_i.mode ? '0 : clamp_dly(act_i.odly, ratio_i);
  assign sdly = act_i.mode ? '0 : clamp_dly(act_i.sdly, ratio_i);

  // phase of the delayed clock, wrapped inside the period
  always_comb begin
    if (cnt_i >= odly) phase = PH_W'(cnt_i - odly);
    else               phase = PH_W'(cnt_i) + PH_W'(ratio_i) - PH_W'(odly);
  end

  assign hi_len = (PH_W'(ratio_i) + PH_W'(1)) >> 1;
  assign mclk_d = act_i.en && (phase < hi_len);
  assign stb_d  = act_i.en && tick_i && (cnt_i == sdly);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      mclk_q <= mclk_d;
      stb_q  <= stb_d;
    end
  end

  assign mclk_o = mclk_q;
  assign stb_o  = stb_q;
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
  import mclkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic             mclk_o,
  output logic             smp_stb_o
);
  cfg_t             shadow;
  cfg_t             act;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] ratio;
  logic             tick;
  logic             term;

  mclk_cfg_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .shadow_o (shadow)
  );

  mclk_div_core u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shadow_i   (shadow),
    .osc_tick_i (osc_tick_i),
    .act_o      (act),
    .cnt_o      (cnt),
    .ratio_o    (ratio),
    .tick_o     (tick),
    .term_o     (term)
  );

  mclk_phase_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .cnt_i   (cnt),
    .ratio_i (ratio),
    .tick_i  (tick),
    .mclk_o  (mclk_o),
    .stb_o   (smp_stb_o)
  );
endmodule

// File: rtl/mclk_gen_chk.sv
module mclk_gen_chk
  import mclkgen_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mclk_i,
  input logic             stb_i,
  input cfg_t             act_i,
  input logic [DIV_W-1:0] cnt_i,
  input logic [DIV_W-1:0] ratio_i,
  input logic             tick_i,
  input logic             term_i
);
  // R1
  dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i.en |=> (!mclk_i && !stb_i));

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.en |-> (cnt_i < ratio_i));

  // R3
  pll_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.en && act_i.src && !term_i) |=> (cnt_i == DIV_W'($past(cnt_i) + DIV_W'(1))));

  // R5
  stb_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> $past(act_i.en));

  // R6
  new_mode_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.en && act_i.mode && tick_i && cnt_i == '0) |=> stb_i);

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(act_i.en) && !$stable(act_i)) |-> $past(term_i));
endmodule

bind mclk_gen mclk_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mclk_i  (mclk_o),
  .stb_i   (smp_stb_o),
  .act_i   (act),
  .cnt_i   (cnt),
  .ratio_i (ratio),
  .tick_i  (tick),
  .term_i  (term)
);

// File: tb/mclk_gen_tb_top.sv
module mclk_gen_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        osc_tick_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [14:0] cfg_wdata_i = '0;
  logic        mclk_o, smp_stb_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  int    osc_every = 3;
  int    osc_ctr = 0;
  bit    done = 0;

  typedef struct { bit ck; bit st; } exp_t;
  exp_t exp_q[$];

  // reference state
  logic [14:0] r_shadow, r_act;
  int          r_cnt;

  always #(CLK_P/2) clk_i = ~clk_i;

  mclk_gen dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .osc_tick_i  (osc_tick_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .mclk_o      (mclk_o),
    .smp_stb_o   (smp_stb_o)
  );

  // oscillator strobe: one cycle in osc_every
  always @(negedge clk_i) begin
    osc_ctr    <= osc_ctr + 1;
    osc_tick_i <= ((osc_ctr + 1) % osc_every) == 0;
  end

  // driver side: model from the requirements, pushes the expected outputs
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      r_shadow = '0; r_act = '0; r_cnt = 0;
      exp_q.delete();
    end else begin
      int d, o, s, ph;
      bit en, tk;
      exp_t e;
      d  = (int'(r_act[3:0]) + 1) << r_act[5:4];
      en = r_act[14];
      tk = r_act[6] ? 1'b1 : osc_tick_i;
      o  = r_act[7] ? 0 : int'(r_act[10:8]);
      s  = r_act[7] ? 0 : int'(r_act[13:11]);
      if (o > d - 1) o = d - 1;
      if (s > d - 1) s = d - 1;
      ph   = (r_cnt - o + d) % d;
      e.ck = en && (ph < (d + 1) / 2);
      e.st = en && tk && (r_cnt == s);
      exp_q.push_back(e);
      if (!en || (tk && r_cnt == d - 1)) begin
        r_act = r_shadow; r_cnt = 0;
      end else if (tk) begin
        r_cnt = r_cnt + 1;
      end
      if (cfg_we_i) r_shadow = cfg_wdata_i;
    end
  end

  // monitor: pops and compares
  always @(negedge clk_i) begin
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (mclk_o !== e.ck || smp_stb_o !== e.st) begin
        errors++;
        $display("FAIL %s mclk/stb actual %b%b expected %b%b at %0t",
                 cur_req, mclk_o, smp_stb_o, e.ck, e.st, $time);
      end
    end
  end

  task automatic cfg_write(input logic [14:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [14:0] word(int m, int n, bit src, bit mode,
                                       int od, int sd, bit en);
    return {en, 3'(sd), 3'(od), mode, src, 2'(n), 4'(m)};
  endfunction

  task automatic measure_period(input int expd, input string tag);
    int  c = 0;
    bit  prev;
    prev = mclk_o;
    for (int i = 0; i < 2000 && !(mclk_o && !prev); i++) begin
      prev = mclk_o; @(negedge clk_i);
    end
    prev = mclk_o;
    @(negedge clk_i); c = 1;
    for (int i = 0; i < 2000 && !(mclk_o && !prev); i++) begin
      prev = mclk_o; @(negedge clk_i); c++;
    end
    checks++;
    if (c != expd) begin
      errors++;
      $display("FAIL %s period actual %0d expected %0d", tag, c, expd);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3);
    // R1: reset state
    checks++;
    if (mclk_o !== 1'b0 || smp_stb_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual %b%b expected 00", mclk_o, smp_stb_o);
    end
    rst_ni = 1'b1;
    cur_req = "R1"; run(20);
    cfg_write(word(3, 0, 1, 0, 0, 0, 0)); run(20);

    // R2: ratios on the PLL path
    cur_req = "R2";
    cfg_write(word(3, 0, 1, 0, 0, 0, 1)); run(30);
    cfg_write(word(4, 1, 1, 0, 0, 0, 1)); run(40);
    measure_period(10, "R2");
    cfg_write(word(2, 0, 1, 0, 0, 0, 1)); run(30);
    cfg_write(word(0, 0, 1, 0, 0, 0, 1)); run(20);
    cfg_write(word(15, 3, 1, 0, 0, 0, 1)); run(300);
    measure_period(128, "R2");

    // R3: oscillator source
    cur_req = "R3";
    cfg_write(word(1, 1, 0, 0, 0, 0, 1)); run(200);
    measure_period(12, "R3");
    osc_every = 5; run(150);

    // R4: output delay, including clamp
    cur_req = "R4"; osc_every = 3;
    cfg_write(word(7, 0, 1, 0, 2, 0, 1)); run(60);
    cfg_write(word(3, 0, 1, 0, 7, 0, 1)); run(60);

    // R5: sample strobe position, including clamp
    cur_req = "R5";
    cfg_write(word(7, 0, 1, 0, 0, 5, 1)); run(60);
    cfg_write(word(2, 0, 0, 0, 0, 7, 1)); run(80);

    // R6: new timing mode bypasses delays
    cur_req = "R6";
    cfg_write(word(7, 0, 1, 1, 6, 4, 1)); run(60);

    // R7: mid-period rewrites and disable at period end
    cur_req = "R7";
    cfg_write(word(15, 2, 1, 0, 1, 2, 1)); run(37);
    cfg_write(word(4, 0, 1, 0, 0, 1, 1)); run(90);
    cfg_write(word(4, 0, 1, 0, 0, 1, 0)); run(40);

    // R8: latency covered cycle by cycle on a fresh enable
    cur_req = "R8";
    cfg_write(word(5, 0, 1, 0, 3, 2, 1)); run(60);

    run(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule